// File: doc/BRIEF.md
# Single-Write I2C Master for a Power-Management Device

This block is an I2C master with a fixed job. It performs one register write on a bus reserved for a power-management device. Software writes a 32-bit command word that holds the target's 7-bit device address, an 8-bit register index, an 8-bit data value and a go flag. When software sets the go flag, the block runs the transfer on its own: START, the address byte with the write bit, the register index, the data value, and then STOP. It checks for an acknowledge after every byte.

A second word sets the length of the SCL high phase and of the SCL low phase, counted in system-clock cycles. Each length is a register value plus a fixed offset. Completion is found by polling. The go flag clears itself once the bus has been released. A sticky error bit records a transfer that ended on a missing acknowledge. The two bus lines are open-drain: each output only pulls its line low or lets it go.

Top module: `pmic_wr_master`

## Requirements
- R1: After reset, both register words read as zero and neither bus line is pulled low.
- R2: The command word holds the device address in bits [6:0], the register index in bits [15:8] and the data value in bits [23:16]. Three bytes go out in this order: {address, 0}, then the register index, then the data value.
- R3: Writing the command word with bit 24 set while bit 24 reads 0 launches a transfer, which begins with a START. While bit 24 is 0, neither line is pulled low.
- R4: Bit 24 reads 1 for the whole transfer and clears by itself in the cycle the bus is released after STOP. Bit 25 reads the error flag, and the other fields read back as written.
- R5: The timing word holds the high count in bits [7:0] and the low count in bits [15:8]. During a transfer, every SCL high pulse ended by a falling edge lasts high count + 5 cycles, and every SCL low pulse lasts low count + 7 cycles. The timing word reads back as written.
- R6: The acknowledge is sampled in the last cycle of the ninth SCL high phase of each byte. If the line is high (no acknowledge), the block goes straight to STOP and sends no further byte. It sets bit 25, which stays set, and still clears bit 24.
- R7: Bit 25 returns to 0 in the cycle a new transfer is launched.
- R8: A command write made while bit 24 is 1 is ignored. It neither restarts the transfer nor changes the bytes sent or the fields read back.
- R9: SDA changes only while SCL has been low for at least one cycle, except in the START and STOP phases.
- R10: The START hold (SDA low before the first SCL fall) and the STOP setup (SCL high with SDA low before SDA rises) each last high count + 5 cycles.
- R11: The timing values are captured when a transfer is launched. A timing write made during a transfer does not affect that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 = command word, 1 = timing word |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| sda_i | input | 1 | Level sensed on the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The self-clearing of the go flag at the end of a transfer can land in the same cycle as a software command write. A write in that cycle still sees the flag set, so it is dropped, and a write one cycle later launches a new transfer. The bench provokes this by holding a command write asserted, carrying new bytes, from launch until past the end of the transfer. It then requires the go flag to read 0 in exactly one sample. It also requires the capturing slave model to see the first transfer's bytes unchanged, followed by a second transfer carrying the new bytes.

// File: rtl/pmic_wr_pkg.sv
package pmic_wr_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_ST_SU,
      SQ_ST_HD,
      SQ_BIT_LO,
      SQ_BIT_HI,
      SQ_SP_LO,
      SQ_SP_SU,
      SQ_SP_BUF
   } sq_state_e;

   localparam int CMD_SA_LSB  = 0;
   localparam int CMD_RA_LSB  = 8;
   localparam int CMD_DT_LSB  = 16;
   localparam int CMD_GO_BIT  = 24;
   localparam int CMD_ERR_BIT = 25;
   localparam int TIM_HI_LSB  = 0;
   localparam int TIM_LO_LSB  = 8;

endpackage

// File: rtl/pmic_phase_timer.sv
module pmic_phase_timer #(
   parameter int W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] len,
   output logic         last
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load)          cnt_q <= len;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   // A phase loaded with N lasts exactly N cycles.
   assign last = (cnt_q == W'(1));

endmodule

// File: rtl/pmic_wr_seq.sv
module pmic_wr_seq
   import pmic_wr_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int HI_OFS = 5,
   parameter int LO_OFS = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] cfg_hi,
   input  logic [CNT_W-1:0] cfg_lo,
   input  logic [7:0]       byte_sa,
   input  logic [7:0]       byte_ra,
   input  logic [7:0]       byte_dt,
   input  logic             sda_i,
   output logic             scl_oe,
   output logic             sda_oe,
   output logic             busy,
   output logic             in_cond,
   output logic             done,
   output logic             nack
);

   localparam int TW        = CNT_W + 1;
   localparam int LAST_BYTE = 2;
   localparam int ACK_BIT   = 8;

   sq_state_e        state_q, state_d;
   logic [CNT_W-1:0] hi_q, lo_q, hi_src, lo_src;
   logic [TW-1:0]    hi_len, lo_len, ph_len;
   logic [3:0]       bit_q;
   logic [1:0]       byte_q;
   logic             sda_q, lo_first, load, last;
   logic [7:0]       cur_byte;
   logic [2:0]       bidx;
   logic             want_low, to_low;

   assign hi_src = (state_q == SQ_IDLE) ? cfg_hi : hi_q;
   assign lo_src = (state_q == SQ_IDLE) ? cfg_lo : lo_q;
   assign hi_len = TW'(hi_src) + TW'(HI_OFS);
   assign lo_len = TW'(lo_src) + TW'(LO_OFS);

   always_comb begin
      unique case (byte_q)
         2'd0:    cur_byte = byte_sa;
         2'd1:    cur_byte = byte_ra;
         default: cur_byte = byte_dt;
      endcase
   end

   assign bidx     = 3'(4'd7 - bit_q);
   assign want_low = (bit_q == 4'(ACK_BIT)) ? 1'b0 : ~cur_byte[bidx];

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SQ_IDLE:   if (start) state_d = SQ_ST_SU;
         SQ_ST_SU:  if (last)  state_d = SQ_ST_HD;
         SQ_ST_HD:  if (last)  state_d = SQ_BIT_LO;
         SQ_BIT_LO: if (last)  state_d = SQ_BIT_HI;
         SQ_BIT_HI: if (last) begin
            if (bit_q == 4'(ACK_BIT) && (sda_i || byte_q == 2'(LAST_BYTE)))
               state_d = SQ_SP_LO;
            else
               state_d = SQ_BIT_LO;
         end
         SQ_SP_LO:  if (last)  state_d = SQ_SP_SU;
         SQ_SP_SU:  if (last)  state_d = SQ_SP_BUF;
         SQ_SP_BUF: if (last)  state_d = SQ_IDLE;
         default:              state_d = SQ_IDLE;
      endcase
   end

   assign load   = (state_d != state_q);
   assign to_low = (state_d == SQ_BIT_LO) || (state_d == SQ_SP_LO);
   assign ph_len = to_low ? lo_len : hi_len;

   pmic_phase_timer #(.W(TW)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .len   (ph_len),
      .last  (last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= SQ_IDLE;
         hi_q     <= '0;
         lo_q     <= '0;
         bit_q    <= '0;
         byte_q   <= '0;
         sda_q    <= 1'b0;
         lo_first <= 1'b0;
      end else begin
         state_q  <= state_d;
         lo_first <= load && to_low;
         if (state_q == SQ_IDLE && start) begin
            hi_q   <= cfg_hi;
            lo_q   <= cfg_lo;
            bit_q  <= '0;
            byte_q <= '0;
         end
         if (state_q == SQ_ST_SU && last)
            sda_q <= 1'b1;
         // SDA moves one cycle after SCL has fallen.
         if (lo_first)
            sda_q <= (state_q == SQ_SP_LO) ? 1'b1 : want_low;
         if (state_q == SQ_BIT_HI && last) begin
            if (bit_q == 4'(ACK_BIT)) begin
               bit_q  <= '0;
               byte_q <= byte_q + 2'd1;
            end else begin
               bit_q  <= bit_q + 4'd1;
            end
         end
      end
   end

   assign scl_oe  = (state_q == SQ_BIT_LO) || (state_q == SQ_SP_LO);
   assign sda_oe  = (state_q == SQ_ST_HD) || (state_q == SQ_SP_SU) ||
                    (sda_q && (state_q == SQ_BIT_LO || state_q == SQ_BIT_HI ||
                               state_q == SQ_SP_LO));
   assign busy    = (state_q != SQ_IDLE);
   assign in_cond = (state_q == SQ_ST_SU) || (state_q == SQ_ST_HD) ||
                    (state_q == SQ_SP_SU) || (state_q == SQ_SP_BUF);
   assign done    = (state_q == SQ_SP_BUF) && last;
   assign nack    = (state_q == SQ_BIT_HI) && last && (bit_q == 4'(ACK_BIT)) && sda_i;

endmodule

// File: rtl/pmic_wr_master.sv
module pmic_wr_master
   import pmic_wr_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int HI_OFS = 5,
   parameter int LO_OFS = 7
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic        reg_sel,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   input  logic        sda_i,
   output logic        scl_oe,
   output logic        sda_oe
);

   localparam int SA_W = 7;
   localparam int FB_W = 8;

   if (CNT_W < 2 || CNT_W > 8) begin : g_bad_cnt_w
      $error("pmic_wr_master: CNT_W must lie in 2..8");
   end
   if (HI_OFS < 2 || LO_OFS < 3) begin : g_bad_ofs
      $error("pmic_wr_master: phase offsets too small");
   end

   logic [SA_W-1:0]  sa_q;
   logic [FB_W-1:0]  ra_q, dt_q;
   logic             go_q, err_q;
   logic [CNT_W-1:0] hi_cfg_q, lo_cfg_q;
   logic             cmd_wr, tim_wr, launch;
   logic             seq_busy, seq_in_cond, seq_done, seq_nack, seq_start;
   logic [31:0]      cmd_rd, tim_rd;
   logic             unused_bits;

   assign cmd_wr    = reg_we && !reg_sel && !go_q;
   assign tim_wr    = reg_we && reg_sel;
   assign launch    = cmd_wr && reg_wdata[CMD_GO_BIT];
   assign seq_start = go_q && !seq_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sa_q     <= '0;
         ra_q     <= '0;
         dt_q     <= '0;
         go_q     <= 1'b0;
         err_q    <= 1'b0;
         hi_cfg_q <= '0;
         lo_cfg_q <= '0;
      end else begin
         if (cmd_wr) begin
            sa_q <= reg_wdata[CMD_SA_LSB +: SA_W];
            ra_q <= reg_wdata[CMD_RA_LSB +: FB_W];
            dt_q <= reg_wdata[CMD_DT_LSB +: FB_W];
            go_q <= reg_wdata[CMD_GO_BIT];
         end else if (seq_done) begin
            go_q <= 1'b0;
         end
         if (launch)        err_q <= 1'b0;
         else if (seq_nack) err_q <= 1'b1;
         if (tim_wr) begin
            hi_cfg_q <= reg_wdata[TIM_HI_LSB +: CNT_W];
            lo_cfg_q <= reg_wdata[TIM_LO_LSB +: CNT_W];
         end
      end
   end

   pmic_wr_seq #(
      .CNT_W  (CNT_W),
      .HI_OFS (HI_OFS),
      .LO_OFS (LO_OFS)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (seq_start),
      .cfg_hi  (hi_cfg_q),
      .cfg_lo  (lo_cfg_q),
      .byte_sa ({sa_q, 1'b0}),
      .byte_ra (ra_q),
      .byte_dt (dt_q),
      .sda_i   (sda_i),
      .scl_oe  (scl_oe),
      .sda_oe  (sda_oe),
      .busy    (seq_busy),
      .in_cond (seq_in_cond),
      .done    (seq_done),
      .nack    (seq_nack)
   );

   always_comb begin
      cmd_rd = '0;
      cmd_rd[CMD_SA_LSB +: SA_W] = sa_q;
      cmd_rd[CMD_RA_LSB +: FB_W] = ra_q;
      cmd_rd[CMD_DT_LSB +: FB_W] = dt_q;
      cmd_rd[CMD_GO_BIT]         = go_q;
      cmd_rd[CMD_ERR_BIT]        = err_q;
      tim_rd = '0;
      tim_rd[TIM_HI_LSB +: CNT_W] = hi_cfg_q;
      tim_rd[TIM_LO_LSB +: CNT_W] = lo_cfg_q;
   end

   assign reg_rdata   = reg_sel ? tim_rd : cmd_rd;
   assign unused_bits = ^{reg_wdata[31:25], reg_wdata[7]};

endmodule

// File: rtl/pmic_wr_master_chk.sv
module pmic_wr_master_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_oe,
   input logic sda_oe,
   input logic go,
   input logic err,
   input logic busy,
   input logic in_cond
);

   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      !go |-> (!scl_oe && !sda_oe)) else $error("lines pulled while idle"); // R3

   AST_GO_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> go) else $error("go flag dropped mid-transfer"); // R4

   AST_LAUNCH_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(go) |-> !err) else $error("error flag kept across launch"); // R7

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(err) |-> $rose(go)) else $error("error flag cleared without launch"); // R6

   AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_cond && !$stable(sda_oe)) |-> (scl_oe && $past(scl_oe)))
      else $error("SDA moved while SCL high"); // R9

endmodule

bind pmic_wr_master pmic_wr_master_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .scl_oe  (scl_oe),
   .sda_oe  (sda_oe),
   .go      (go_q),
   .err     (err_q),
   .busy    (seq_busy),
   .in_cond (seq_in_cond)
);

// File: tb/tb_pmic_wr_master.sv
module tb_pmic_wr_master;

   localparam int CLK_PERIOD = 10;
   localparam int POLL_MAX   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic        reg_sel = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        scl_oe, sda_oe, scl_w, sda_w;
   logic        slv_low = 1'b0;

   int tests = 0;
   int fails = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign scl_w = ~scl_oe;
   assign sda_w = ~(sda_oe | slv_low);

   pmic_wr_master dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .sda_i     (sda_w),
      .scl_oe    (scl_oe),
      .sda_oe    (sda_oe)
   );

   // ---------------- slave model and bus monitor ----------------
   int   starts, stops, nb, bitc, run, hl, stop_su;
   int   hi_min, hi_max, lo_min, lo_max;
   int   nack_at = -1;
   bit   act, clr;
   logic p_scl = 1'b1, p_sda = 1'b1;
   logic [7:0] sh;
   logic [7:0] cap [8];

   always @(negedge clk) begin
      if (!rst_n || clr) begin
         starts = 0; stops = 0; nb = 0; bitc = 0; run = 0; hl = 0; stop_su = 0;
         hi_min = 99999; hi_max = 0; lo_min = 99999; lo_max = 0;
         act = 0; slv_low = 1'b0; sh = '0;
      end else begin
         if (scl_w && p_scl && p_sda && !sda_w) begin
            starts++; act = 1; bitc = 0; run = 1;
         end else if (scl_w && p_scl && !p_sda && sda_w) begin
            stops++; act = 0; stop_su = hl; slv_low = 1'b0;
         end else begin
            if (scl_w != p_scl) begin
               if (act) begin
                  if (p_scl) begin
                     if (run < hi_min) hi_min = run;
                     if (run > hi_max) hi_max = run;
                  end else begin
                     if (run < lo_min) lo_min = run;
                     if (run > lo_max) lo_max = run;
                  end
               end
               run = 1;
            end else begin
               run++;
            end
            if (act && scl_w && !p_scl) begin
               if (bitc < 8) begin
                  sh = {sh[6:0], sda_w};
                  bitc++;
                  if (bitc == 8 && nb < 8) begin
                     cap[nb] = sh;
                     nb++;
                  end
               end else begin
                  bitc = 9;
               end
            end
            if (act && !scl_w && p_scl) begin
               if (bitc == 8)      slv_low = (nack_at != nb - 1);
               else if (bitc == 9) begin slv_low = 1'b0; bitc = 0; end
            end
         end
         if (scl_w && !p_scl)     hl = !sda_w ? 1 : 0;
         else if (scl_w && !sda_w) hl++;
      end
      p_scl = scl_w;
      p_sda = sda_w;
   end

   // ---------------- helpers ----------------
   task automatic chk_eq(input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
      tests++;
      if (act_v !== exp_v) begin
         fails++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act_v, exp_v);
      end
   endtask

   function automatic logic [31:0] cmdw(input logic [6:0] sa, input logic [7:0] ra,
                                        input logic [7:0] dt, input bit go, input bit er);
      return {6'b0, er, go, dt, ra, 1'b0, sa};
   endfunction

   task automatic wr(input logic sel, input logic [31:0] d);
      @(negedge clk);
      reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic sel, output logic [31:0] v);
      @(negedge clk);
      reg_sel = sel;
      #1 v = reg_rdata;
   endtask

   task automatic clear_stats();
      clr = 1;
      @(negedge clk);
      @(negedge clk);
      clr = 0;
   endtask

   task automatic wait_done(input string req);
      int n = 0;
      do begin
         @(negedge clk);
         reg_sel = 1'b0;
         #1 n++;
      end while (reg_rdata[24] && n < POLL_MAX);
      chk_eq({req, " completion before poll limit"}, 32'(n < POLL_MAX), 32'd1);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      logic [31:0] v;
      rd(1'b0, v); chk_eq("R1 command word after reset", v, 32'h0);
      rd(1'b1, v); chk_eq("R1 timing word after reset", v, 32'h0);
      chk_eq("R1 lines released after reset", {30'b0, scl_oe, sda_oe}, 32'h0);
   endtask

   task automatic t_basic();
      logic [31:0] v;
      clear_stats();
      wr(1'b1, {16'h0, 8'd4, 8'd3});
      wr(1'b0, cmdw(7'h5A, 8'h3C, 8'hA5, 1, 0));
      rd(1'b0, v); chk_eq("R3 go flag set after launch", 32'(v[24]), 32'd1);
      wait_done("R4");
      chk_eq("R3 one START", starts, 1);
      chk_eq("R2 byte count", nb, 3);
      chk_eq("R2 address byte", cap[0], 8'hB4);
      chk_eq("R2 register byte", cap[1], 8'h3C);
      chk_eq("R2 data byte", cap[2], 8'hA5);
      chk_eq("R5 SCL high min", hi_min, 8);
      chk_eq("R5 SCL high max", hi_max, 8);
      chk_eq("R5 SCL low min", lo_min, 11);
      chk_eq("R5 SCL low max", lo_max, 11);
      chk_eq("R10 STOP setup", stop_su, 8);
      chk_eq("R10 one STOP", stops, 1);
      rd(1'b0, v); chk_eq("R4 readback after completion", v, cmdw(7'h5A, 8'h3C, 8'hA5, 0, 0));
      chk_eq("R3 lines released after completion", {30'b0, scl_oe, sda_oe}, 32'h0);
   endtask

   task automatic t_midwrite();
      logic [31:0] v;
      clear_stats();
      wr(1'b1, {16'h0, 8'd20, 8'd10});
      wr(1'b0, cmdw(7'h21, 8'hFF, 8'h00, 1, 0));
      repeat (200) @(negedge clk);
      wr(1'b1, {16'h0, 8'd1, 8'd1});
      wr(1'b0, cmdw(7'h7F, 8'h11, 8'h22, 1, 0));
      rd(1'b0, v); chk_eq("R8 busy write ignored in readback", v, cmdw(7'h21, 8'hFF, 8'h00, 1, 0));
      wait_done("R8");
      chk_eq("R8 one START only", starts, 1);
      chk_eq("R8 byte count", nb, 3);
      chk_eq("R8 address byte kept", cap[0], 8'h42);
      chk_eq("R8 register byte kept", cap[1], 8'hFF);
      chk_eq("R8 data byte kept", cap[2], 8'h00);
      chk_eq("R11 SCL high held", hi_max, 15);
      chk_eq("R11 SCL high min held", hi_min, 15);
      chk_eq("R11 SCL low held", lo_max, 27);
      chk_eq("R11 SCL low min held", lo_min, 27);
      rd(1'b1, v); chk_eq("R5 timing word readback", v, {16'h0, 8'd1, 8'd1});
   endtask

   task automatic t_nack();
      logic [31:0] v;
      wr(1'b1, {16'h0, 8'd4, 8'd3});
      nack_at = 1;
      clear_stats();
      wr(1'b0, cmdw(7'h30, 8'h44, 8'h55, 1, 0));
      wait_done("R6");
      chk_eq("R6 bytes before stop", nb, 2);
      chk_eq("R6 STOP issued", stops, 1);
      rd(1'b0, v); chk_eq("R6 error set, go cleared", 32'(v[25:24]), 32'd2);
      repeat (50) @(negedge clk);
      rd(1'b0, v); chk_eq("R6 error sticky", 32'(v[25]), 32'd1);
      nack_at = -1;
   endtask

   task automatic t_errclear();
      logic [31:0] v;
      clear_stats();
      wr(1'b0, cmdw(7'h12, 8'h34, 8'h56, 1, 0));
      rd(1'b0, v); chk_eq("R7 error cleared at launch", 32'(v[25:24]), 32'd1);
      wait_done("R7");
      chk_eq("R7 full transfer", nb, 3);
      chk_eq("R7 data byte", cap[2], 8'h56);
   endtask

   task automatic t_back2back();
      int zeros = 0;
      int n = 0;
      bit seen_one = 0;
      clear_stats();
      wr(1'b0, cmdw(7'h0F, 8'h81, 8'h7E, 1, 0));
      @(negedge clk);
      reg_sel = 1'b0; reg_wdata = cmdw(7'h70, 8'h09, 8'hC3, 1, 0); reg_we = 1'b1;
      do begin
         @(negedge clk);
         #1 n++;
         if (!reg_rdata[24]) zeros++;
         else if (zeros > 0) seen_one = 1;
      end while (!seen_one && n < POLL_MAX);
      reg_we = 1'b0;
      chk_eq("R4 go reads 0 for one sample at end", zeros, 1);
      wait_done("R8");
      chk_eq("R8 two transfers", nb, 6);
      chk_eq("R8 first transfer address", cap[0], 8'h1E);
      chk_eq("R8 first transfer data", cap[2], 8'h7E);
      chk_eq("R3 second transfer address", cap[3], 8'hE0);
      chk_eq("R3 second transfer data", cap[5], 8'hC3);
   endtask

   // ---------------- sequencing ----------------
   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_midwrite();
      t_nack();
      t_errclear();
      t_back2back();
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule